// File: doc/BRIEF.md
# Two-Cycle Complex Mixer with Fused First Integrator

This block mixes a complex baseband stream with a local oscillator without ever forming the complex product explicitly. A complex sample arrives as two real words on one port: the in-phase word first, tagged as in-phase, then the quadrature word, tagged as quadrature. On each accepted word two real multipliers form one partial product for the I path and one for the Q path. Those products go straight into the first integrator of a decimating comb-integrator filter. After the quadrature word, the I integrator has gained I·cos − Q·sin and the Q integrator has gained I·sin + Q·cos. Together these are the full complex product.

The later filter stages may read the integrators only once both halves of a pair are in. For that reason the filter that follows must decimate by exactly two. A one-cycle strobe marks each point where a complete pair has been folded in. The oscillator and the later filter stages are outside this block. The cosine and sine words must stay the same across both words of a pair.

Top module: `cplx_mix_integ`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both integrator outputs read zero and `pair_done` reads 0.
- R2: An accepted word with `in_is_i`=1 (in-phase tag) adds `in_data`×`lo_cos` to `integ_i` and `in_data`×`lo_sin` to `integ_q`. The new values are visible after the next rising clock edge.
- R3: An accepted word with `in_is_i`=0 (quadrature tag) subtracts `in_data`×`lo_sin` from `integ_i` and adds `in_data`×`lo_cos` to `integ_q`. The new values are visible after the next rising clock edge.
- R4: When `in_valid` is 0, both integrators hold their values and `pair_done` is 0 in the following cycle.
- R5: `pair_done` is 1 for exactly the one cycle after a quadrature word is accumulated, and only if the last word accepted before it was in-phase. A quadrature word that follows another quadrature word leaves `pair_done` at 0. So does a quadrature word accepted first after reset.
- R6: Products are full-precision signed values. The integrators are `DW+CW+GW` bits wide and wrap in two's complement on overflow.
- R7: Over one in-phase word followed by one quadrature word, with constant oscillator values, `integ_i` changes by I·cos − Q·sin and `integ_q` changes by I·sin + Q·cos. Both changes are taken modulo 2^(`DW+CW+GW`).
- R8: `pair_done` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High when `in_data` carries a word to accumulate |
| in_is_i | input | 1 | Phase tag: 1 for the in-phase word, 0 for the quadrature word |
| in_data | input | DW | Signed sample word |
| lo_cos | input | CW | Signed oscillator cosine |
| lo_sin | input | CW | Signed oscillator sine |
| integ_i | output | DW+CW+GW | Signed I-path first-integrator state |
| integ_q | output | DW+CW+GW | Signed Q-path first-integrator state |
| pair_done | output | 1 | One-cycle strobe: a complete complex product has been accumulated |

## Verification
The embedded assertions run on every cycle. They check that the integrators hold when no word is accepted, that the strobe appears only right after a quadrature accumulation and never right after an in-phase one, and that the strobe never lasts two cycles. The bench scenarios cover the behaviour the assertions do not. A scoreboard checks the exact arithmetic of each partial product, including the sign on the Q×sine term. It also checks two's-complement wrap under sustained full-scale input, the strobe after a pair that begins with repeated in-phase words, and a direct port-level comparison of one full pair against the complex product.

// File: rtl/cplx_mix_integ.sv
module cplx_mix_integ #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int GW = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_is_i,
  input  logic signed [DW-1:0]     in_data,
  input  logic signed [CW-1:0]     lo_cos,
  input  logic signed [CW-1:0]     lo_sin,
  output logic signed [DW+CW+GW-1:0] integ_i,
  output logic signed [DW+CW+GW-1:0] integ_q,
  output logic                     pair_done
);
  localparam int PW = DW + CW;
  localparam int AW = PW + GW;

  logic signed [PW-1:0] din_x, coef_i, coef_q, prod_i, prod_q;
  logic signed [AW-1:0] term_i, term_q;
  logic                 last_was_i;

  // Operand steering: in-phase word uses (cos, sin), quadrature word uses (sin, cos)
  assign din_x  = PW'(in_data);
  assign coef_i = in_is_i ? PW'(lo_cos) : PW'(lo_sin);
  assign coef_q = in_is_i ? PW'(lo_sin) : PW'(lo_cos);
  assign prod_i = din_x * coef_i;
  assign prod_q = din_x * coef_q;

  // Q x sine enters the I path with a minus sign
  assign term_i = in_is_i ? AW'(prod_i) : -AW'(prod_i);
  assign term_q = AW'(prod_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ_i    <= '0;
      integ_q    <= '0;
      pair_done  <= 1'b0;
      last_was_i <= 1'b0;
    end else begin
      pair_done <= in_valid && !in_is_i && last_was_i;
      if (in_valid) begin
        integ_i    <= integ_i + term_i;
        integ_q    <= integ_q + term_q;
        last_was_i <= in_is_i;
      end
    end
  end

  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(integ_i) && $stable(integ_q) && !pair_done));

  assert_done_follows_quad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_i) |=> !pair_done);

  assert_done_needs_quad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |-> $past(in_valid && !in_is_i));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |=> !pair_done);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (integ_i == '0 && integ_q == '0 && !pair_done));
endmodule

// File: tb/tb_cplx_mix_integ.sv
module tb_cplx_mix_integ;
  localparam int DW = 16, CW = 16, GW = 2;
  localparam int AW = DW + CW + GW;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_is_i = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic signed [CW-1:0] lo_cos = '0, lo_sin = '0;
  logic signed [AW-1:0] integ_i, integ_q;
  logic pair_done;

  cplx_mix_integ #(.DW(DW), .CW(CW), .GW(GW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_i(in_is_i),
    .in_data(in_data), .lo_cos(lo_cos), .lo_sin(lo_sin),
    .integ_i(integ_i), .integ_q(integ_q), .pair_done(pair_done));

  always #10 clk = ~clk;

  typedef struct {
    logic signed [AW-1:0] ei;
    logic signed [AW-1:0] eq;
    logic                 ed;
    string                tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0;
  logic signed [AW-1:0] ref_i = '0, ref_q = '0;
  logic ref_last_i = 1'b0;
  bit monitor_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit isi, input int x, input int c,
                       input int s, input string tag);
    exp_t e;
    longint pa, pb;
    @(negedge clk);
    in_valid = v; in_is_i = isi;
    in_data = DW'(x); lo_cos = CW'(c); lo_sin = CW'(s);
    e.ed = v && !isi && ref_last_i;
    if (v) begin
      if (isi) begin
        pa = longint'(x) * c; pb = longint'(x) * s;
        ref_i = ref_i + AW'(pa);
        ref_q = ref_q + AW'(pb);
      end else begin
        pa = longint'(x) * s; pb = longint'(x) * c;
        ref_i = ref_i - AW'(pa);
        ref_q = ref_q + AW'(pb);
      end
      ref_last_i = isi;
    end
    e.ei = ref_i; e.eq = ref_q; e.tag = tag;
    sb.push_back(e);
  endtask

  always begin
    @(posedge clk);
    #5;
    if (monitor_on && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(integ_i == e.ei, e.tag, "integ_i", longint'(integ_i), longint'(e.ei));
      chk(integ_q == e.eq, e.tag, "integ_q", longint'(integ_q), longint'(e.eq));
      chk(pair_done == e.ed, e.tag, "pair_done", longint'(pair_done), longint'(e.ed));
    end
  end

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic signed [AW-1:0] i0, q0;
    longint ex_i, ex_q;
    int xi, xq, c, s;
    repeat (3) @(posedge clk);
    #5;
    chk(integ_i == 0 && integ_q == 0, "R1", "integrators in reset",
        longint'(integ_i), 0);
    chk(pair_done == 1'b0, "R1", "pair_done in reset", longint'(pair_done), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    chk(integ_i == 0 && integ_q == 0 && !pair_done, "R1", "first cycle after reset",
        longint'(integ_i), 0);
    monitor_on = 1'b1;

    // R5: quadrature first after reset gives no strobe
    drive(1, 0, 1000, 300, -200, "R3/R5 lone quad");
    drive(0, 0, 0, 0, 0, "R4 idle");
    // R2, R3 fixed pairs
    drive(1, 1, 1234, 5000, -7000, "R2 in-phase");
    drive(1, 0, -321, 5000, -7000, "R3/R5 quad completes pair");
    drive(0, 1, 77, 1, 1, "R4 idle ignores data");
    // R5: quad after quad gives no strobe
    drive(1, 0, 50, 9, 11, "R5 quad after quad");
    // R5: two in-phase words then quad
    drive(1, 1, 10, 3, 4, "R2 in-phase repeated");
    drive(1, 1, -20, 3, 4, "R2 in-phase repeated");
    drive(1, 0, 30, 3, 4, "R5 strobe after repeated in-phase");
    drive(1, 1, 7, 3, 4, "R8 back-to-back pair");
    drive(1, 0, -7, 3, 4, "R8 back-to-back pair");
    // random pairs, gaps between halves
    for (int k = 0; k < 40; k++) begin
      c = rnd16(); s = rnd16();
      drive(1, 1, rnd16(), c, s, "R2 random");
      if (k % 3 == 0) drive(0, 0, rnd16(), rnd16(), rnd16(), "R4 random gap");
      drive(1, 0, rnd16(), c, s, "R3 random");
    end
    // R6: full-scale accumulation wraps
    for (int k = 0; k < 12; k++)
      drive(1, 1, -32768, -32768, 32767, "R6 wrap");
    drive(0, 0, 0, 0, 0, "R6 idle");

    // R7: direct port comparison of one pair
    wait (sb.size() == 0);
    #1;
    i0 = integ_i; q0 = integ_q;
    xi = -12345; xq = 23456; c = 30000; s = -17000;
    drive(1, 1, xi, c, s, "R7 pair I");
    drive(1, 0, xq, c, s, "R7 pair Q");
    drive(0, 0, 0, 0, 0, "R7 idle");
    wait (sb.size() == 0);
    #1;
    ex_i = longint'(xi) * c - longint'(xq) * s;
    ex_q = longint'(xi) * s + longint'(xq) * c;
    chk(integ_i - i0 == AW'(ex_i), "R7", "I delta",
        longint'(AW'(integ_i - i0)), ex_i);
    chk(integ_q - q0 == AW'(ex_q), "R7", "Q delta",
        longint'(AW'(integ_q - q0)), ex_q);

    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule